// File: doc/BRIEF.md
# Six-Channel Serial Audio Transmit Port

This block drives six channels of 24-bit PCM onto three serial data lines. Each line carries one fixed pair of channels. The bit clock and the word clock come from outside the block and are shared by all three lines. The block samples both clocks with its own system clock, corrects their polarity, and detects the falling edge of the corrected bit clock. Each output bit is launched on that edge, so a receiver can capture it on the next rising edge. A producer delivers a complete set of six samples through a valid/ready handshake. The block holds one set in a staging buffer and moves it into the active set at the start of each frame.

A small set of configuration inputs controls the framing. One bit inverts the bit clock and one bit inverts the word clock. A 2-bit code selects the frame format and another 2-bit code selects the word length. The format and word-length codes are captured only at the word-clock edge that opens a frame, so one frame never uses two settings. If no staged set is waiting when a frame opens, the frame carries zeros and a sticky underrun flag is raised.

The sequencer has three states, and every transition happens on a bit-clock launch edge:
- `PH_IDLE` is the state after reset, and the outputs are held at zero. It moves to `PH_LEFT` when the corrected word clock falls from high to low. This is the first frame start.
- `PH_LEFT` covers the low half of the word clock. It moves to `PH_RIGHT` when the corrected word clock rises.
- `PH_RIGHT` covers the high half of the word clock. It moves back to `PH_LEFT` when the corrected word clock falls. Each such transition opens a new frame.

Top module: `sap_tx`

## Requirements
- R1: After reset, `sd_out` is all zero, `underrun` is 0 and `smp_ready` is 1.
- R2: Channel c (0..5) occupies `smp_data[24*c+23 : 24*c]`. The channels are 0 = left, 1 = right, 2 = left surround, 3 = right surround, 4 = centre and 5 = LFE. Line l carries channel 2l in the left half-frame and channel 2l+1 in the right half-frame, MSB first.
- R3: With `cfg_bclk_inv`=0, each bit is launched after a falling edge of `bclk_in` and is stable at the following rising edge. With `cfg_bclk_inv`=1, the roles of the two edges swap.
- R4: With `cfg_wclk_inv`=0, the left half-frame is the time `wclk_in` is low and the right half-frame is the time it is high. With `cfg_wclk_inv`=1, this is reversed. The slot count restarts at each word-clock change seen at a launch edge.
- R5: Format code 00 (left-justified), and the spare code 11 which behaves the same, places the sample MSB in the first slot of each half-frame.
- R6: Format code 01 (I2S) drives zero in the first slot of each half-frame and places the MSB in the second slot.
- R7: Format code 10 (right-justified) places the last valid bit in the last slot of the half-frame. The half-frame length is the slot count of the previous half-frame, or `DEF_HALF` slots before any half-frame has been measured.
- R8: Word-length codes 00/01/10/11 select 16/18/20/24 bits. A shorter word is the upper part of the 24-bit sample. Every slot outside the valid bits drives zero.
- R9: `cfg_fmt` and `cfg_wlen` are captured at the word-clock edge that opens a left half-frame. A change during a frame has no effect until the next frame.
- R10: The staging buffer holds one sample set. `smp_ready` is 1 only when the buffer is empty. A set is accepted on a clock where `smp_valid` and `smp_ready` are both 1. The buffer empties at the next frame start.
- R11: If a frame opens with the staging buffer empty, the whole frame is zero on all lines and `underrun` becomes 1. It stays 1 until reset.
- R12: Between reset and the first frame start, all lines drive zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it oversamples the serial clocks |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_in | input | 1 | External bit clock |
| wclk_in | input | 1 | External word clock |
| cfg_bclk_inv | input | 1 | Inverts the active edge of the bit clock |
| cfg_wclk_inv | input | 1 | Inverts the word-clock polarity |
| cfg_fmt | input | 2 | Frame format code |
| cfg_wlen | input | 2 | Word-length code |
| smp_valid | input | 1 | A sample set is offered |
| smp_ready | output | 1 | The staging buffer is empty |
| smp_data | input | 2*LINES*24 | Six packed 24-bit samples |
| sd_out | output | LINES | Serial data lines |
| underrun | output | 1 | Sticky flag: a frame opened with no data |

## Verification
A new bit on `sd_out` is due `SYNC+1` system-clock cycles after the raw bit-clock edge that launches it, because of the synchronizer stages and the output register. The bench holds each bit-clock half period for four system-clock cycles and reads every slot just before it drives the rising edge, which is one cycle after the bit is due. `smp_ready` falls one cycle after an accepted handshake, so the bench checks it at the following falling edge of `clk`. `underrun` and the return of `smp_ready` are checked after a whole frame has been driven, well after the frame-start edge that updates them.

// File: rtl/sap_pkg.sv
package sap_pkg;

    localparam int SMP_W = 24;

    typedef enum logic [1:0] {
        FMT_LEFT  = 2'b00,
        FMT_I2S   = 2'b01,
        FMT_RIGHT = 2'b10,
        FMT_ALT   = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'b00,
        PH_LEFT  = 2'b01,
        PH_RIGHT = 2'b10
    } phase_e;

    function automatic int word_bits(input logic [1:0] code);
        case (code)
            2'b00:   return 16;
            2'b01:   return 18;
            2'b10:   return 20;
            default: return 24;
        endcase
    endfunction

endpackage

// File: rtl/sap_edge_det.sv
// Polarity correction and synchronization of the external serial clocks.
// SYNC must be at least 2.
module sap_edge_det #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_in,
    input  logic wclk_in,
    input  logic inv_b,
    input  logic inv_w,
    output logic launch,
    output logic wlvl
);

    logic [SYNC:0]   bsh;
    logic [SYNC-1:0] wsh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bsh <= '0;
            wsh <= '0;
        end else begin
            bsh <= {bsh[SYNC-1:0], bclk_in ^ inv_b};
            wsh <= {wsh[SYNC-2:0], wclk_in ^ inv_w};
        end
    end

    // falling edge of the corrected bit clock; word level taken at the same depth
    assign launch = bsh[SYNC] & ~bsh[SYNC-1];
    assign wlvl   = wsh[SYNC-1];

endmodule

// File: rtl/sap_sample_buf.sv
// One staging entry plus the active set used by the current frame.
module sap_sample_buf #(
    parameter int W = 144
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         in_ready,
    input  logic         take,
    output logic [W-1:0] cur_data,
    output logic         underrun
);

    logic [W-1:0] stage;
    logic [W-1:0] act;
    logic         full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage    <= '0;
            act      <= '0;
            full     <= 1'b0;
            underrun <= 1'b0;
        end else begin
            if (take) begin
                if (full) begin
                    act  <= stage;
                    full <= 1'b0;
                end else begin
                    act      <= '0;
                    underrun <= 1'b1;
                end
            end
            if (in_valid && !full) begin
                stage <= in_data;
                full  <= 1'b1;
            end
        end
    end

    assign in_ready = ~full;
    assign cur_data = take ? (full ? stage : '0) : act;

endmodule

// File: rtl/sap_slot_bit.sv
// Chooses the bit a line drives in one slot, from format, word length and position.
module sap_slot_bit
    import sap_pkg::*;
#(
    parameter int SLOT_W = 6
) (
    input  logic [1:0]       fmt,
    input  logic [1:0]       wlen,
    input  logic [SLOT_W-1:0] pos,
    input  logic [SLOT_W:0]   half_len,
    input  logic [SMP_W-1:0]  word,
    output logic              bit_o
);

    int p, hl, wl, off, k;
    logic [SMP_W-1:0] sh;

    always_comb begin
        p   = int'(pos);
        hl  = int'(half_len);
        wl  = word_bits(wlen);
        off = (hl > wl) ? hl - wl : 0;
        unique case (fmt_e'(fmt))
            FMT_I2S:   k = p - 1;
            FMT_RIGHT: k = p - off;
            default:   k = p;
        endcase
        sh    = '0;
        bit_o = 1'b0;
        if (k >= 0 && k < wl) begin
            sh    = word << k;
            bit_o = sh[SMP_W-1];
        end
    end

endmodule

// File: rtl/sap_tx.sv
module sap_tx
    import sap_pkg::*;
#(
    parameter int LINES    = 3,
    parameter int SLOT_W   = 6,
    parameter int DEF_HALF = 32,
    parameter int SYNC     = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bclk_in,
    input  logic                         wclk_in,
    input  logic                         cfg_bclk_inv,
    input  logic                         cfg_wclk_inv,
    input  logic [1:0]                   cfg_fmt,
    input  logic [1:0]                   cfg_wlen,
    input  logic                         smp_valid,
    output logic                         smp_ready,
    input  logic [2*LINES*SMP_W-1:0]     smp_data,
    output logic [LINES-1:0]             sd_out,
    output logic                         underrun
);

    localparam int CH = 2 * LINES;
    localparam int W  = CH * SMP_W;
    localparam logic [SLOT_W-1:0] POS_MAX = {SLOT_W{1'b1}};

    logic              launch, wlvl, w_prev;
    logic              boundary, take;
    phase_e            state, state_nx;
    logic [SLOT_W-1:0] pos;
    logic [SLOT_W:0]   half_len, eff_half;
    logic [1:0]        fmt_q, wlen_q, eff_fmt, eff_wlen;
    logic [W-1:0]      eff_data;
    logic [LINES-1:0]  line_bit;

    sap_edge_det #(.SYNC(SYNC)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .bclk_in(bclk_in),
        .wclk_in(wclk_in),
        .inv_b  (cfg_bclk_inv),
        .inv_w  (cfg_wclk_inv),
        .launch (launch),
        .wlvl   (wlvl)
    );

    assign boundary = launch && (wlvl != w_prev);
    assign take     = boundary && !wlvl;

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            PH_IDLE:  if (take)              state_nx = PH_LEFT;
            PH_LEFT:  if (boundary && wlvl)  state_nx = PH_RIGHT;
            PH_RIGHT: if (take)              state_nx = PH_LEFT;
            default:                         state_nx = PH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PH_IDLE;
        else        state <= state_nx;
    end

    // slot position, half-frame length and frame-held configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_prev   <= 1'b0;
            pos      <= '0;
            half_len <= (SLOT_W+1)'(DEF_HALF);
            fmt_q    <= '0;
            wlen_q   <= '0;
        end else if (launch) begin
            w_prev <= wlvl;
            if (boundary) begin
                pos <= '0;
                if (state != PH_IDLE) half_len <= eff_half;
            end else if (pos != POS_MAX) begin
                pos <= pos + 1'b1;
            end
            if (take) begin
                fmt_q  <= cfg_fmt;
                wlen_q <= cfg_wlen;
            end
        end
    end

    assign eff_half = (boundary && state != PH_IDLE) ? ({1'b0, pos} + 1'b1) : half_len;
    assign eff_fmt  = take ? cfg_fmt  : fmt_q;
    assign eff_wlen = take ? cfg_wlen : wlen_q;

    sap_sample_buf #(.W(W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(smp_valid),
        .in_data (smp_data),
        .in_ready(smp_ready),
        .take    (take),
        .cur_data(eff_data),
        .underrun(underrun)
    );

    logic [SLOT_W-1:0] slot_nx;
    assign slot_nx = boundary ? '0 : ((pos == POS_MAX) ? pos : pos + 1'b1);

    for (genvar l = 0; l < LINES; l++) begin : g_line
        logic [SMP_W-1:0] word;
        assign word = (state_nx == PH_RIGHT) ? eff_data[SMP_W*(2*l+1) +: SMP_W]
                                             : eff_data[SMP_W*(2*l)   +: SMP_W];
        sap_slot_bit #(.SLOT_W(SLOT_W)) u_bit (
            .fmt     (eff_fmt),
            .wlen    (eff_wlen),
            .pos     (slot_nx),
            .half_len(eff_half),
            .word    (word),
            .bit_o   (line_bit[l])
        );
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sd_out <= '0;
        else if (launch) sd_out <= (state_nx == PH_IDLE) ? '0 : line_bit;
    end

endmodule

// File: rtl/sap_tx_chk.sv
module sap_tx_chk
    import sap_pkg::*;
#(
    parameter int LINES  = 3,
    parameter int SLOT_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              launch,
    input logic              boundary,
    input logic              take,
    input phase_e            state,
    input logic [1:0]        fmt_q,
    input logic [SLOT_W-1:0] pos,
    input logic [LINES-1:0]  sd_out,
    input logic              underrun,
    input logic              smp_valid,
    input logic              smp_ready
);

    assert_accept_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_ready) |=> !smp_ready);

    assert_underrun_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);

    assert_cfg_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(fmt_q));

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_IDLE) |-> (sd_out == '0));

    assert_launch_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !launch |=> $stable(sd_out));

    assert_slot_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> (pos == '0));

endmodule

bind sap_tx sap_tx_chk #(.LINES(LINES), .SLOT_W(SLOT_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .boundary (boundary),
    .take     (take),
    .state    (state),
    .fmt_q    (fmt_q),
    .pos      (pos),
    .sd_out   (sd_out),
    .underrun (underrun),
    .smp_valid(smp_valid),
    .smp_ready(smp_ready)
);

// File: tb/test_sap_tx.sv
`timescale 1ns/1ps
module test_sap_tx;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bclk_in = 1'b1, wclk_in = 1'b1;
    logic         cfg_bclk_inv = 1'b0, cfg_wclk_inv = 1'b0;
    logic [1:0]   cfg_fmt = 2'b00, cfg_wlen = 2'b11;
    logic         smp_valid = 1'b0;
    logic         smp_ready;
    logic [143:0] smp_data = '0;
    logic [2:0]   sd_out;
    logic         underrun;

    int n_chk = 0, n_fail = 0;
    logic [63:0] cap [3];

    always #2.5 clk = ~clk;

    sap_tx i_sap_tx (
        .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .wclk_in(wclk_in),
        .cfg_bclk_inv(cfg_bclk_inv), .cfg_wclk_inv(cfg_wclk_inv),
        .cfg_fmt(cfg_fmt), .cfg_wlen(cfg_wlen),
        .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
        .sd_out(sd_out), .underrun(underrun)
    );

    // {bclk inv, wclk inv, fmt[1:0], wlen[1:0], 2'b0, seed[7:0]}
    localparam logic [15:0] VEC [9] = '{
        {1'b0, 1'b0, 2'b00, 2'b11, 2'b00, 8'h11},
        {1'b0, 1'b0, 2'b01, 2'b11, 2'b00, 8'h22},
        {1'b0, 1'b0, 2'b10, 2'b11, 2'b00, 8'h33},
        {1'b0, 1'b0, 2'b00, 2'b00, 2'b00, 8'h44},
        {1'b0, 1'b0, 2'b10, 2'b01, 2'b00, 8'h55},
        {1'b0, 1'b0, 2'b01, 2'b10, 2'b00, 8'h66},
        {1'b1, 1'b0, 2'b11, 2'b11, 2'b00, 8'h77},
        {1'b0, 1'b1, 2'b01, 2'b00, 2'b00, 8'h88},
        {1'b1, 1'b1, 2'b10, 2'b10, 2'b00, 8'h99}
    };

    function automatic logic [143:0] mk_set(input logic [7:0] seed);
        logic [143:0] s;
        for (int c = 0; c < 6; c++)
            s[24*c +: 24] = {seed ^ 8'hA5, seed + 8'(c*29+1), ~seed ^ 8'(c*7)};
        return s;
    endfunction

    // slot i of a frame is bit i; slots 0..31 left half, 32..63 right half
    function automatic logic [63:0] exp_line(input int l, input logic [1:0] f,
                                             input logic [1:0] wc, input logic [143:0] s);
        logic [63:0] r;
        logic [23:0] w;
        int wl, k;
        wl = (wc == 2'b00) ? 16 : (wc == 2'b01) ? 18 : (wc == 2'b10) ? 20 : 24;
        r = '0;
        for (int h = 0; h < 2; h++) begin
            w = s[24*(2*l+h) +: 24];
            for (int p = 0; p < 32; p++) begin
                if (f == 2'b01)      k = p - 1;
                else if (f == 2'b10) k = p - (32 - wl);
                else                 k = p;
                r[h*32+p] = (k >= 0 && k < wl) ? w[23-k] : 1'b0;
            end
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [143:0] d);
        @(negedge clk);
        while (!smp_ready) @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = d;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic slot(input logic wl, output logic [2:0] got);
        @(negedge clk);
        bclk_in = 1'b0 ^ cfg_bclk_inv;
        wclk_in = wl ^ cfg_wclk_inv;
        repeat (4) @(negedge clk);
        got = sd_out;
        bclk_in = 1'b1 ^ cfg_bclk_inv;
        repeat (3) @(negedge clk);
    endtask

    task automatic run_frame(input logic chg, input logic [1:0] nf, input logic [1:0] nw);
        logic [2:0] g;
        for (int i = 0; i < 64; i++) begin
            if (chg && i == 10) begin
                cfg_fmt  = nf;
                cfg_wlen = nw;
            end
            slot(i >= 32, g);
            for (int l = 0; l < 3; l++) cap[l][i] = g[l];
        end
    endtask

    task automatic check_frame(input string req, input logic [1:0] f,
                               input logic [1:0] wc, input logic [143:0] s);
        for (int l = 0; l < 3; l++) check(req, cap[l], exp_line(l, f, wc, s));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [2:0]   g;
        logic [63:0]  idle_or;
        logic [143:0] sa, sb, sc, sd;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset outputs", {59'd0, sd_out, underrun, smp_ready}, 64'h1);

        // R12 quiet before first frame start (word clock high only)
        idle_or = '0;
        for (int i = 0; i < 4; i++) begin
            slot(1'b1, g);
            idle_or[2:0] = idle_or[2:0] | g;
        end
        check("R12 idle lines", idle_or, 64'h0);

        // vector table: R2..R8 over formats, lengths and polarities
        for (int v = 0; v < 9; v++) begin
            logic [143:0] s;
            @(negedge clk);
            cfg_bclk_inv = VEC[v][15];
            cfg_wclk_inv = VEC[v][14];
            bclk_in      = 1'b1 ^ VEC[v][15];
            wclk_in      = 1'b1 ^ VEC[v][14];
            cfg_fmt      = VEC[v][13:12];
            cfg_wlen     = VEC[v][11:10];
            s = mk_set(VEC[v][7:0]);
            push(s);
            run_frame(1'b0, 2'b00, 2'b00);
            check_frame("R2 R3 R4 R5 R6 R7 R8 vector", VEC[v][13:12], VEC[v][11:10], s);
            check("R11 no spurious underrun", {63'd0, underrun}, 64'h0);
        end

        // directed: return to plain polarity
        @(negedge clk);
        cfg_bclk_inv = 1'b0; cfg_wclk_inv = 1'b0;
        bclk_in = 1'b1; wclk_in = 1'b1;
        cfg_fmt = 2'b00; cfg_wlen = 2'b11;

        // R10 one-entry staging and back-pressure
        sa = mk_set(8'hC3);
        push(sa);
        @(negedge clk);
        check("R10 ready low while staged", {63'd0, smp_ready}, 64'h0);
        run_frame(1'b0, 2'b00, 2'b00);
        check_frame("R10 staged set sent", 2'b00, 2'b11, sa);
        check("R10 ready after frame start", {63'd0, smp_ready}, 64'h1);

        // R9 mid-frame configuration change is deferred
        sb = mk_set(8'h5A);
        push(sb);
        run_frame(1'b1, 2'b10, 2'b00);
        check_frame("R9 old config kept", 2'b00, 2'b11, sb);
        sc = mk_set(8'hE1);
        push(sc);
        run_frame(1'b0, 2'b00, 2'b00);
        check_frame("R9 new config next frame", 2'b10, 2'b00, sc);

        // R11 underrun: zeros and sticky flag
        check("R11 flag clear before", {63'd0, underrun}, 64'h0);
        run_frame(1'b0, 2'b00, 2'b00);
        check_frame("R11 zero frame", 2'b10, 2'b00, 144'd0);
        check("R11 flag raised", {63'd0, underrun}, 64'h1);
        sd = mk_set(8'h3C);
        push(sd);
        run_frame(1'b0, 2'b00, 2'b00);
        check_frame("R11 data resumes", 2'b10, 2'b00, sd);
        check("R11 flag sticky", {63'd0, underrun}, 64'h1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule